// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table out of memory. A request carries a virtual page number and the frame number of the top-level directory. The upper bits of the page number pick a directory entry; if that entry is valid, its frame number locates a second-level table, and the lower bits of the page number pick the leaf entry inside it. The leaf entry is handed back so that a translation cache can be loaded with it. An invalid entry at either level ends the walk with a fault that names the failing level. Pages are 4 KB, so the 12-bit page offset never takes part in the walk.

The walker handles one walk at a time. It takes a request over a valid/ready handshake, reads memory through a request/response port, and offers the result on a valid/ready handshake. Back-pressure rules: a request is taken only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while no walk is in progress. A memory read is posted by `mem_req_valid` and stays unchanged until `mem_req_ready` is seen high. The response port has no ready signal: one response per posted read is expected, and it may arrive any number of cycles later. A result stays on its pins until `res_ready` is high.

Top module: `pt_walker`

## Requirements
- R1: After reset, and whenever a walk is in progress or a result is waiting, only the idle state allows a new request: `req_ready` is 1 in idle and 0 otherwise; in idle `mem_req_valid` and `res_valid` are 0. An asynchronous low `rst_n` returns the walker to idle from any state.
- R2: In the cycle after a request is accepted, a read is posted at address {directory frame, page number bits 19:10, 2'b00}.
- R3: A posted read keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is sampled high; in the cycle after that, `mem_req_valid` is 0.
- R4: An entry is valid when its bit 0 is 1, and bits 31:12 hold a frame number. When the directory entry is valid, the walker posts a second read at {directory entry bits 31:12, page number bits 9:0, 2'b00}.
- R5: When the directory entry is invalid, no second read is posted and the result has `res_fault`=1, `res_fault_level`=0 (directory), and `res_pte` equal to the directory entry.
- R6: When the leaf entry is valid, the result has `res_fault`=0 and `res_pte` equal to the leaf entry.
- R7: When the leaf entry is invalid, the result has `res_fault`=1, `res_fault_level`=1 (leaf), and `res_pte` equal to the leaf entry.
- R8: The result appears in the cycle after the deciding response; while `res_ready` is 0 it holds `res_valid`, `res_pte`, `res_fault` and `res_fault_level` steady and refuses requests. After the handshake the walker is idle in the next cycle.
- R9: A response that arrives when no read is outstanding (in idle, or while a read is still waiting for `mem_req_ready`) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vpn | input | 20 | Virtual page number (directory index in the upper 10 bits, table index in the lower 10) |
| req_dir_frame | input | 20 | Frame number of the top-level directory |
| mem_req_valid | output | 1 | Memory read posted |
| mem_req_ready | input | 1 | Memory takes the posted read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Walk result available |
| res_ready | input | 1 | Consumer takes the result |
| res_pte | output | 32 | Leaf entry, or the invalid entry that caused a fault |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_fault_level | output | 1 | Failing level: 0 directory, 1 leaf |

## Verification
The bench builds the walker with its default shape: 32-bit addresses, 12 offset bits, 10-bit directory and table indices and 4-byte entries. With those values an index of all ones lands on the last word of a 4 KB table and a frame of all ones reaches the top of the address space, so the vectors can probe both ends of each address field and catch a carry or slice error. Varied memory stall and latency counts, stray responses and a held result exercise every waiting state of the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    W_IDLE     = 3'd0,
    W_DIR_REQ  = 3'd1,
    W_DIR_WAIT = 3'd2,
    W_TBL_REQ  = 3'd3,
    W_TBL_WAIT = 3'd4,
    W_DONE     = 3'd5,
    W_FAULT    = 3'd6
  } walk_state_e;

  typedef enum logic {
    LVL_DIR  = 1'b0,
    LVL_LEAF = 1'b1
  } walk_level_e;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        rsp_ok,
  output walk_level_e addr_level,
  output logic        cap_req,
  output logic        cap_dir,
  output logic        fin,
  output walk_level_e fin_level,
  output logic        res_valid,
  input  logic        res_ready
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      W_IDLE:     if (req_valid)     state_d = W_DIR_REQ;
      W_DIR_REQ:  if (mem_req_ready) state_d = W_DIR_WAIT;
      W_DIR_WAIT: if (mem_rsp_valid) state_d = rsp_ok ? W_TBL_REQ : W_FAULT;
      W_TBL_REQ:  if (mem_req_ready) state_d = W_TBL_WAIT;
      W_TBL_WAIT: if (mem_rsp_valid) state_d = rsp_ok ? W_DONE : W_FAULT;
      W_DONE,
      W_FAULT:    if (res_ready)     state_d = W_IDLE;
      default:                       state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= W_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready     = (state_q == W_IDLE);
  assign mem_req_valid = (state_q == W_DIR_REQ) || (state_q == W_TBL_REQ);
  assign addr_level    = ((state_q == W_TBL_REQ) || (state_q == W_TBL_WAIT)) ? LVL_LEAF : LVL_DIR;
  assign cap_req       = (state_q == W_IDLE) && req_valid;
  assign cap_dir       = (state_q == W_DIR_WAIT) && mem_rsp_valid && rsp_ok;
  assign fin           = ((state_q == W_DIR_WAIT) && mem_rsp_valid && !rsp_ok) ||
                         ((state_q == W_TBL_WAIT) && mem_rsp_valid);
  assign fin_level     = (state_q == W_TBL_WAIT) ? LVL_LEAF : LVL_DIR;
  assign res_valid     = (state_q == W_DONE) || (state_q == W_FAULT);

  // R1: idle excludes any posted read or pending result
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  // R5: invalid directory entry ends the walk in the fault state
  p_dir_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_DIR_WAIT && mem_rsp_valid && !rsp_ok) |=> (state_q == W_FAULT));

  // R9: a response while a read is still unaccepted leaves the walk where it is
  p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_DIR_REQ && !mem_req_ready) |=> (state_q == W_DIR_REQ));

endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int ESH   = 2,
  localparam int VPN_W = DIR_W + TBL_W,
  localparam int PFN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_req,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PFN_W-1:0] req_dir_frame,
  input  logic             cap_dir,
  input  logic [PFN_W-1:0] dir_entry_frame,
  input  walk_level_e      addr_level,
  output logic [PA_W-1:0]  mem_req_addr
);

  logic [VPN_W-1:0] vpn_q;
  logic [PFN_W-1:0] dir_frame_q;
  logic [PFN_W-1:0] tbl_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q       <= '0;
      dir_frame_q <= '0;
      tbl_frame_q <= '0;
    end else begin
      if (cap_req) begin
        vpn_q       <= req_vpn;
        dir_frame_q <= req_dir_frame;
      end
      if (cap_dir) tbl_frame_q <= dir_entry_frame;
    end
  end

  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;
  logic [PA_W-1:0]  idx_ext;
  logic [PFN_W-1:0] frame_sel;
  logic [PA_W-1:0]  base;

  assign dir_idx   = vpn_q[VPN_W-1 -: DIR_W];
  assign tbl_idx   = vpn_q[TBL_W-1:0];
  assign idx_ext   = (addr_level == LVL_LEAF) ? PA_W'(tbl_idx) : PA_W'(dir_idx);
  assign frame_sel = (addr_level == LVL_LEAF) ? tbl_frame_q : dir_frame_q;
  assign base      = {frame_sel, {OFF_W{1'b0}}};

  assign mem_req_addr = base + (idx_ext << ESH);

endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptw_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int VALID_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fin,
  input  walk_level_e     fin_level,
  input  logic [PA_W-1:0] entry,
  output logic [PA_W-1:0] res_pte,
  output logic            res_fault,
  output logic            res_fault_level
);

  logic entry_bad;
  assign entry_bad = !entry[VALID_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pte         <= '0;
      res_fault       <= 1'b0;
      res_fault_level <= 1'b0;
    end else if (fin) begin
      res_pte         <= entry;
      res_fault       <= entry_bad;
      res_fault_level <= entry_bad && (fin_level == LVL_LEAF);
    end
  end

  // R6: a valid leaf is returned unchanged with no fault
  p_leaf_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_level == LVL_LEAF && entry[VALID_BIT]) |=>
      (!res_fault && res_pte == $past(entry)));

  // R7: an invalid leaf faults at the leaf level
  p_leaf_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_level == LVL_LEAF && !entry[VALID_BIT]) |=>
      (res_fault && res_fault_level));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int PA_W        = 32,
  parameter int OFF_W       = 12,
  parameter int DIR_W       = 10,
  parameter int TBL_W       = 10,
  parameter int ENTRY_BYTES = 4,
  parameter int VALID_BIT   = 0,
  localparam int VPN_W = DIR_W + TBL_W,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int ESH   = $clog2(ENTRY_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PFN_W-1:0] req_dir_frame,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PA_W-1:0]  mem_rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [PA_W-1:0]  res_pte,
  output logic             res_fault,
  output logic             res_fault_level
);

  walk_level_e addr_level;
  walk_level_e fin_level;
  logic        cap_req;
  logic        cap_dir;
  logic        fin;

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_ok        (mem_rsp_data[VALID_BIT]),
    .addr_level    (addr_level),
    .cap_req       (cap_req),
    .cap_dir       (cap_dir),
    .fin           (fin),
    .fin_level     (fin_level),
    .res_valid     (res_valid),
    .res_ready     (res_ready)
  );

  ptw_addr #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W),
    .DIR_W (DIR_W),
    .TBL_W (TBL_W),
    .ESH   (ESH)
  ) u_addr (
    .clk             (clk),
    .rst_n           (rst_n),
    .cap_req         (cap_req),
    .req_vpn         (req_vpn),
    .req_dir_frame   (req_dir_frame),
    .cap_dir         (cap_dir),
    .dir_entry_frame (mem_rsp_data[PA_W-1:OFF_W]),
    .addr_level      (addr_level),
    .mem_req_addr    (mem_req_addr)
  );

  ptw_result #(
    .PA_W      (PA_W),
    .VALID_BIT (VALID_BIT)
  ) u_result (
    .clk             (clk),
    .rst_n           (rst_n),
    .fin             (fin),
    .fin_level       (fin_level),
    .entry           (mem_rsp_data),
    .res_pte         (res_pte),
    .res_fault       (res_fault),
    .res_fault_level (res_fault_level)
  );

  // R2: first read targets the selected directory word
  p_dir_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (mem_req_valid &&
       mem_req_addr == ({$past(req_dir_frame), {OFF_W{1'b0}}} +
                        (PA_W'($past(req_vpn[VPN_W-1 -: DIR_W])) << ESH))));

  // R3: a posted read is held until taken
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: a pending result is held until taken
  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_pte) && $stable(res_fault) && $stable(res_fault_level)));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  typedef struct packed {
    logic [19:0] vpn;
    logic [19:0] dframe;
    logic [31:0] dpte;
    logic [31:0] lpte;
    logic [3:0]  bp;
    logic [3:0]  lat;
    logic        stray;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{20'h00000, 20'h00010, 32'h00020001, 32'h12345007, 4'd0, 4'd0, 1'b0},
    '{20'hFFFFF, 20'hABCDE, 32'hFFFFF001, 32'h00001003, 4'd2, 4'd3, 1'b1},
    '{20'h12345, 20'h00100, 32'h55555000, 32'h00000000, 4'd1, 4'd1, 1'b0},
    '{20'h3FF00, 20'h00ABC, 32'h7777700F, 32'hABCDEFFE, 4'd0, 4'd2, 1'b0},
    '{20'h00400, 20'h00001, 32'h000000FF, 32'hFFFFFFFF, 4'd3, 4'd0, 1'b1},
    '{20'h003FF, 20'hFFFFF, 32'h80000001, 32'h00000001, 4'd0, 4'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic [19:0] req_dir_frame = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_pte;
  logic        res_fault;
  logic        res_fault_level;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vpn         (req_vpn),
    .req_dir_frame   (req_dir_frame),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_data    (mem_rsp_data),
    .res_valid       (res_valid),
    .res_ready       (res_ready),
    .res_pte         (res_pte),
    .res_fault       (res_fault),
    .res_fault_level (res_fault_level)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Serve one posted read: stall, optional stray response, accept, latency, reply.
  task automatic serve(input logic [31:0] addr, input int bp, input bit stray,
                       input int lat, input logic [31:0] data, input int n);
    for (int i = 0; i < bp; i++) begin
      if (stray && i == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hFFFFFFFF;
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R3", $sformatf("v%0d read held", n), {31'd0, mem_req_valid}, 32'd1);
      chk(stray ? "R9" : "R3", $sformatf("v%0d addr held", n), mem_req_addr, addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R3", $sformatf("v%0d read dropped after accept", n), {31'd0, mem_req_valid}, 32'd0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    logic [31:0] a_dir, a_tbl, e_pte;
    logic        e_fault, e_lvl;
    a_dir   = {v.dframe, v.vpn[19:10], 2'b00};
    a_tbl   = {v.dpte[31:12], v.vpn[9:0], 2'b00};
    e_fault = !v.dpte[0] || !v.lpte[0];
    e_lvl   = v.dpte[0] && !v.lpte[0];
    e_pte   = v.dpte[0] ? v.lpte : v.dpte;

    @(negedge clk);
    chk("R1", $sformatf("v%0d ready in idle", n), {31'd0, req_ready}, 32'd1);
    req_valid     = 1'b1;
    req_vpn       = v.vpn;
    req_dir_frame = v.dframe;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", $sformatf("v%0d busy after accept", n), {31'd0, req_ready}, 32'd0);
    chk("R2", $sformatf("v%0d dir read posted", n), {31'd0, mem_req_valid}, 32'd1);
    chk("R2", $sformatf("v%0d dir addr", n), mem_req_addr, a_dir);
    serve(a_dir, int'(v.bp), v.stray, int'(v.lat), v.dpte, n);

    if (v.dpte[0]) begin
      chk("R4", $sformatf("v%0d table read posted", n), {31'd0, mem_req_valid}, 32'd1);
      chk("R4", $sformatf("v%0d table addr", n), mem_req_addr, a_tbl);
      serve(a_tbl, int'(v.bp), 1'b0, int'(v.lat), v.lpte, n);
    end else begin
      chk("R5", $sformatf("v%0d no second read", n), {31'd0, mem_req_valid}, 32'd0);
    end

    chk("R8", $sformatf("v%0d result valid", n), {31'd0, res_valid}, 32'd1);
    if (!v.dpte[0]) begin
      chk("R5", $sformatf("v%0d fault", n), {31'd0, res_fault}, 32'd1);
      chk("R5", $sformatf("v%0d level", n), {31'd0, res_fault_level}, 32'd0);
      chk("R5", $sformatf("v%0d pte", n), res_pte, e_pte);
    end else if (v.lpte[0]) begin
      chk("R6", $sformatf("v%0d fault", n), {31'd0, res_fault}, 32'd0);
      chk("R6", $sformatf("v%0d pte", n), res_pte, e_pte);
    end else begin
      chk("R7", $sformatf("v%0d fault", n), {31'd0, res_fault}, {31'd0, e_fault});
      chk("R7", $sformatf("v%0d level", n), {31'd0, res_fault_level}, {31'd0, e_lvl});
      chk("R7", $sformatf("v%0d pte", n), res_pte, e_pte);
    end

    req_valid = 1'b1;
    @(negedge clk);
    chk("R8", $sformatf("v%0d result held", n), {31'd0, res_valid}, 32'd1);
    chk("R8", $sformatf("v%0d pte held", n), res_pte, e_pte);
    chk("R8", $sformatf("v%0d request refused", n), {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R8", $sformatf("v%0d result taken", n), {31'd0, res_valid}, 32'd0);
    chk("R8", $sformatf("v%0d idle again", n), {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "reset no read", {31'd0, mem_req_valid}, 32'd0);
    chk("R1", "reset no result", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) run_vec(VECS[n], n);

    // R9: response in idle has no effect
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h12345000;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    chk("R9", "idle stray ready", {31'd0, req_ready}, 32'd1);
    chk("R9", "idle stray no read", {31'd0, mem_req_valid}, 32'd0);
    chk("R9", "idle stray no result", {31'd0, res_valid}, 32'd0);

    // R1: reset in the middle of a walk
    req_valid     = 1'b1;
    req_vpn       = 20'h00801;
    req_dir_frame = 20'h00042;
    @(negedge clk);
    req_valid     = 1'b0;
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "mid-walk reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "mid-walk reset no read", {31'd0, mem_req_valid}, 32'd0);
    chk("R1", "mid-walk reset no result", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // walk after reset behaves normally
    run_vec('{20'h00801, 20'h00042, 32'h00099001, 32'h0ABCD005, 4'd1, 4'd1, 1'b0}, 99);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule